// File: doc/BRIEF.md
# System Exception Pending Control Register Block

This block holds the pending flags of three system exceptions and gives software a way to set or clear them through a word-wide register bus. The three exceptions are a non-maskable exception, a deferred-service exception and a periodic tick exception. It also lets software trigger any external interrupt by writing its number to a separate trigger register. That number is checked against the configured interrupt count before the block raises a trigger pulse.

On a read, the control register shows several values together. It shows the vector now being serviced and the highest pending vector, when one exists. It also shows a flag set when any external interrupt is pending, and the three pending flags. Hardware sources, such as the tick timer, can raise a pending flag directly with a one-cycle pulse. A separate register returns the interrupt count in units of 32. Priority arbitration and exception entry belong to the surrounding controller.

Top module: `irqpend_top`

## Requirements
- R1: After a synchronous active-low reset, all three pending flags are 0 and `sw_trig` is all zeros.
- R2: A write to offset 0xD04 with bit 31 set makes the non-maskable flag 1 from the next cycle on. No write clears this flag; only reset clears it.
- R3: A write to 0xD04 with bit 28 set makes the deferred-service flag 1. A write with bit 27 set and bit 28 clear makes it 0. When bits 28 and 27 are both set, the flag is set.
- R4: A write to 0xD04 with bit 26 set makes the tick flag 1. A write with bit 25 set and bit 26 clear makes it 0. When bits 26 and 25 are both set, the flag is set.
- R5: A one-cycle hardware set pulse makes the matching flag 1 in the next cycle. This holds even when a software clear of that flag happens in the same cycle.
- R6: A pending flag keeps its value in any cycle with no set or clear for it. Writes to offsets other than 0xD04 leave all three flags unchanged.
- R7: A write to offset 0xF00 takes bits 8:0 as an interrupt number n and ignores bits 31:9. If n is below `NUM_IRQ`, `sw_trig[n]` is high for exactly the one cycle after the write, and all other trigger bits stay low.
- R8: A write to 0xF00 with n equal to or above `NUM_IRQ` raises no trigger bit.
- R9: Reading 0xD04 returns the following fields. Bits 8:0 hold `act_vec`. Bits 20:12 hold `top_vec` when `top_vec_vld` is 1, and 0 otherwise. Bit 22 is the OR of `ext_pend`. Bits 31, 28 and 26 hold the non-maskable, deferred-service and tick flags. All other bits read 0.
- R10: Reading offset 0x004 returns NUM_IRQ/32 − 1. Reads of any other offset, including 0xF00, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_nmi_set | input | 1 | Hardware set pulse, non-maskable exception |
| hw_defer_set | input | 1 | Hardware set pulse, deferred-service exception |
| hw_tick_set | input | 1 | Hardware set pulse, tick exception |
| act_vec | input | 9 | Vector currently in service |
| top_vec | input | 9 | Highest pending vector |
| top_vec_vld | input | 1 | `top_vec` names a real pending vector |
| ext_pend | input | NUM_IRQ | Pending state of each external interrupt |
| nmi_pend | output | 1 | Non-maskable exception pending |
| defer_pend | output | 1 | Deferred-service exception pending |
| tick_pend | output | 1 | Tick exception pending |
| sw_trig | output | NUM_IRQ | One-cycle software trigger per external interrupt |

## Verification
The assertions assume that `bus_wr` and the hardware set pulses are known (never X) whenever reset is released. They also assume that a write's effect shows one cycle later, with no other write to the same register in between. The bench meets this by driving every input at the falling edge, holding it for exactly one cycle and then returning the strobes to 0. It samples the flags and triggers at the next falling edge. Hardware pulses are only raised together with a single write, so each register step has a single, predictable outcome.

// File: rtl/irqpend_pkg.sv
`timescale 1ns/1ps
// Package: shared offsets, field positions and exception indices for the
// pending control block. Assumes a 12-bit byte offset and 32-bit data.
package irqpend_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int VEC_W  = 9;
    localparam int NUM_EXC = 3;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTL   = 12'hD04;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 12'hF00;

    // Exception slots, used to index the per-exception arrays below.
    typedef enum int {EXC_NMI = 0, EXC_DEFER = 1, EXC_TICK = 2} exc_idx_e;

    localparam int SET_BIT [NUM_EXC] = '{31, 28, 26};
    localparam int CLR_BIT [NUM_EXC] = '{0, 27, 25};
    localparam bit HAS_CLR [NUM_EXC] = '{1'b0, 1'b1, 1'b1};

    localparam int TOPVEC_LSB  = 12;
    localparam int EXTPEND_BIT = 22;
endpackage

// File: rtl/irqpend_flag.sv
`timescale 1ns/1ps
// Module: one pending flag with software set, optional software clear and a
// hardware set pulse. Any set beats a clear in the same cycle.
// Assumes inputs are synchronous to clk.
module irqpend_flag #(
    parameter bit HAS_CLR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_set,
    output logic q
);
    logic clr_en;
    logic any_set;

    // Purpose: drop the clear path for flags that cannot be cleared.
    generate
        if (HAS_CLR) begin : g_clr
            assign clr_en = sw_clr;
        end else begin : g_noclr
            assign clr_en = 1'b0;
        end
    endgenerate

    assign any_set = sw_set | hw_set;

    // Purpose: update the flag, set first, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (any_set)  q <= 1'b1;
        else if (clr_en)   q <= 1'b0;
    end

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> q); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_set && !hw_set && !sw_clr) |=> $stable(q)); // R6
endmodule

// File: rtl/irqpend_trig.sv
`timescale 1ns/1ps
// Module: software trigger decoder. A write carries a 9-bit interrupt number;
// numbers below NUM_IRQ give a one-cycle pulse on the matching output bit.
// Assumes NUM_IRQ is at most 496.
module irqpend_trig #(
    parameter int NUM_IRQ = 64,
    parameter int VEC_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [VEC_W-1:0]   num,
    output logic [NUM_IRQ-1:0] trig
);
    localparam logic [VEC_W:0] LIMIT = (VEC_W+1)'(NUM_IRQ);

    logic               in_range;
    logic [NUM_IRQ-1:0] trig_d;

    assign in_range = ({1'b0, num} < LIMIT);

    // Purpose: one comparator per interrupt line builds the next pulse vector.
    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
            assign trig_d[i] = wr && in_range && (num == VEC_W'(i));
        end
    endgenerate

    // Purpose: register the pulse so it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= '0;
        else        trig <= trig_d;
    end

    AST_TRIG_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $onehot0(trig)); // R7
    AST_TRIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ({1'b0, num} >= LIMIT)) |=> (trig == '0)); // R8
    AST_TRIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> (trig == '0)); // R7
endmodule

// File: rtl/irqpend_rdmux.sv
`timescale 1ns/1ps
// Module: read data assembly for the count and control registers.
// Purely combinational; reads have no side effects.
module irqpend_rdmux
    import irqpend_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [VEC_W-1:0]   act_vec,
    input  logic [VEC_W-1:0]   top_vec,
    input  logic               top_vec_vld,
    input  logic [NUM_IRQ-1:0] ext_pend,
    input  logic [NUM_EXC-1:0] pend,
    output logic [DATA_W-1:0]  rdata
);
    localparam int COUNT_VAL = NUM_IRQ / 32 - 1;

    logic [DATA_W-1:0] ctl_word;

    // Purpose: pack the control register fields.
    always_comb begin
        ctl_word = '0;
        ctl_word[VEC_W-1:0] = act_vec;
        if (top_vec_vld) ctl_word[TOPVEC_LSB +: VEC_W] = top_vec;
        ctl_word[EXTPEND_BIT] = |ext_pend;
        for (int e = 0; e < NUM_EXC; e++) begin
            ctl_word[SET_BIT[e]] = pend[e];
        end
    end

    // Purpose: select the word for the addressed register.
    always_comb begin
        unique case (addr)
            OFS_COUNT: rdata = DATA_W'(COUNT_VAL);
            OFS_CTL:   rdata = ctl_word;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqpend_top.sv
`timescale 1ns/1ps
// Module: system exception pending control block. Decodes bus writes into
// per-exception set/clear strobes and software triggers, and serves reads.
// Assumes one write per cycle at most and synchronous hardware pulses.
module irqpend_top
    import irqpend_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               hw_nmi_set,
    input  logic               hw_defer_set,
    input  logic               hw_tick_set,
    input  logic [8:0]         act_vec,
    input  logic [8:0]         top_vec,
    input  logic               top_vec_vld,
    input  logic [NUM_IRQ-1:0] ext_pend,
    output logic               nmi_pend,
    output logic               defer_pend,
    output logic               tick_pend,
    output logic [NUM_IRQ-1:0] sw_trig
);
    logic               wr_ctl;
    logic               wr_trig;
    logic [NUM_EXC-1:0] hw_set;
    logic [NUM_EXC-1:0] pend;

    // Purpose: decode which register a write targets.
    assign wr_ctl  = bus_wr && (bus_addr == OFS_CTL);
    assign wr_trig = bus_wr && (bus_addr == OFS_TRIG);

    assign hw_set[EXC_NMI]   = hw_nmi_set;
    assign hw_set[EXC_DEFER] = hw_defer_set;
    assign hw_set[EXC_TICK]  = hw_tick_set;

    // Purpose: one pending flag per system exception.
    generate
        for (genvar g = 0; g < NUM_EXC; g++) begin : g_exc
            irqpend_flag #(.HAS_CLR(HAS_CLR[g])) u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .sw_set (wr_ctl && bus_wdata[SET_BIT[g]]),
                .sw_clr (wr_ctl && bus_wdata[CLR_BIT[g]]),
                .hw_set (hw_set[g]),
                .q      (pend[g])
            );
        end
    endgenerate

    assign nmi_pend   = pend[EXC_NMI];
    assign defer_pend = pend[EXC_DEFER];
    assign tick_pend  = pend[EXC_TICK];

    irqpend_trig #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_trig),
        .num   (bus_wdata[VEC_W-1:0]),
        .trig  (sw_trig)
    );

    irqpend_rdmux #(.NUM_IRQ(NUM_IRQ)) u_rd (
        .addr        (bus_addr),
        .act_vec     (act_vec),
        .top_vec     (top_vec),
        .top_vec_vld (top_vec_vld),
        .ext_pend    (ext_pend),
        .pend        (pend),
        .rdata       (bus_rdata)
    );

    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |=> nmi_pend); // R2
    AST_NMI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[31]) |=> nmi_pend); // R2
    AST_DEFER_SET_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[28]) |=> defer_pend); // R3
    AST_DEFER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[27] && !bus_wdata[28] && !hw_defer_set) |=> !defer_pend); // R3
    AST_TICK_SET_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[26]) |=> tick_pend); // R4
    AST_TICK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[25] && !bus_wdata[26] && !hw_tick_set) |=> !tick_pend); // R4
    AST_OTHER_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctl && hw_set == '0) |=> $stable(pend)); // R6
endmodule

// File: tb/tb_irqpend_top.sv
`timescale 1ns/1ps
// Bench: table-driven walk over flag set/clear writes, then directed checks
// of reset, triggers and read fields.
module tb_irqpend_top;
    localparam int NUM_IRQ = 64;
    localparam int NVEC = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               hw_nmi_set = 1'b0, hw_defer_set = 1'b0, hw_tick_set = 1'b0;
    logic [8:0]         act_vec = '0, top_vec = '0;
    logic               top_vec_vld = 1'b0;
    logic [NUM_IRQ-1:0] ext_pend = '0;
    logic               nmi_pend, defer_pend, tick_pend;
    logic [NUM_IRQ-1:0] sw_trig;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0]         cap_pend;
    logic [NUM_IRQ-1:0] cap_trig;

    always #10 clk = ~clk;

    irqpend_top #(.NUM_IRQ(NUM_IRQ)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_nmi_set(hw_nmi_set), .hw_defer_set(hw_defer_set), .hw_tick_set(hw_tick_set),
        .act_vec(act_vec), .top_vec(top_vec), .top_vec_vld(top_vec_vld),
        .ext_pend(ext_pend), .nmi_pend(nmi_pend), .defer_pend(defer_pend),
        .tick_pend(tick_pend), .sw_trig(sw_trig)
    );

    // Vector: {addr[11:0], wdata[31:0], hw{nmi,defer,tick}[2:0], expected pend{nmi,defer,tick}[2:0]}
    localparam logic [49:0] VECS [NVEC] = '{
        {12'hD04, 32'h1000_0000, 3'b000, 3'b010},  // R3 set deferred
        {12'hD04, 32'h0400_0000, 3'b000, 3'b011},  // R4 set tick
        {12'hD04, 32'h0800_0000, 3'b000, 3'b001},  // R3 clear deferred
        {12'hD04, 32'h1800_0000, 3'b000, 3'b011},  // R3 set beats clear
        {12'hD04, 32'h0200_0000, 3'b000, 3'b010},  // R4 clear tick
        {12'hD04, 32'h0A00_0000, 3'b001, 3'b001},  // R5 hw tick beats sw clear
        {12'h010, 32'hFFFF_FFFF, 3'b000, 3'b001},  // R6 other offset ignored
        {12'hD04, 32'h8000_0000, 3'b000, 3'b101},  // R2 set NMI
        {12'hD04, 32'h0A00_0000, 3'b000, 3'b100},  // R2 NMI survives, R4 clear
        {12'h000, 32'h0000_0000, 3'b010, 3'b110},  // R5 hw deferred alone
        {12'hD04, 32'h0800_0000, 3'b010, 3'b110},  // R5 hw deferred beats clear
        {12'hD04, 32'h0000_0000, 3'b000, 3'b110}   // R6 empty write holds
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus from a falling edge, capture outputs at the next.
    task automatic step(input logic [11:0] a, input logic [31:0] d, input logic w, input logic [2:0] hw);
        bus_addr = a; bus_wdata = d; bus_wr = w;
        {hw_nmi_set, hw_defer_set, hw_tick_set} = hw;
        @(negedge clk);
        cap_pend = {nmi_pend, defer_pend, tick_pend};
        cap_trig = sw_trig;
        bus_wr = 1'b0; {hw_nmi_set, hw_defer_set, hw_tick_set} = 3'b000;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pend after reset", {61'd0, nmi_pend, defer_pend, tick_pend}, 64'd0);
        check("R1 trig after reset", 64'(sw_trig), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            step(VECS[k][49:38], VECS[k][37:6], 1'b1, VECS[k][5:3]);
            check($sformatf("R2-R6 flag vector %0d", k), 64'(cap_pend), 64'(VECS[k][2:0]));
        end

        // R7 trigger in range, pulse lasts one cycle
        step(12'hF00, 32'd5, 1'b1, 3'b000);
        check("R7 trig n=5", 64'(cap_trig), 64'd1 << 5);
        step(12'h000, 32'd0, 1'b0, 3'b000);
        check("R7 trig pulse ends", 64'(cap_trig), 64'd0);
        // R7 upper bits ignored, top line
        step(12'hF00, 32'hABCD_FE3F, 1'b1, 3'b000);
        check("R7 trig n=63 upper ignored", 64'(cap_trig), 64'd1 << 63);
        // R8 out of range
        step(12'hF00, 32'd64, 1'b1, 3'b000);
        check("R8 trig n=64", 64'(cap_trig), 64'd0);
        step(12'hF00, 32'h0000_01FF, 1'b1, 3'b000);
        check("R8 trig n=511", 64'(cap_trig), 64'd0);
        check("R6 trig write leaves flags", 64'(cap_pend), 64'b110);

        // R9 control read with all fields
        act_vec = 9'h1A3; top_vec = 9'h025; top_vec_vld = 1'b1;
        ext_pend = 64'd1 << 40; bus_addr = 12'hD04;
        #1;
        check("R9 ctl read full", 64'(bus_rdata), 64'h9042_51A3);
        top_vec_vld = 1'b0; ext_pend = '0;
        #1;
        check("R9 ctl read no pending vec", 64'(bus_rdata), 64'h9000_01A3);
        // R10 count and other reads
        bus_addr = 12'h004;
        #1;
        check("R10 count read", 64'(bus_rdata), 64'd1);
        bus_addr = 12'hF00;
        #1;
        check("R10 trig reads zero", 64'(bus_rdata), 64'd0);
        @(negedge clk);

        // R1 reset mid-run clears the sticky NMI flag
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pend after second reset", {61'd0, nmi_pend, defer_pend, tick_pend}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule